// File: doc/BRIEF.md
# Low-Power Clock Gating Controller

This block decides, every cycle, which clock domains of a small processor subsystem may toggle. It produces one gate enable each for the CPU, the flash interface, the SRAM interface, the DMA engine, every peripheral on the peripheral bus, and the bridge in front of that bus. It also produces the run enables for the high-speed internal oscillator, the 14 MHz internal oscillator, the high-speed external oscillator, the PLL and the low-speed internal oscillator, plus a gated clock enable for the independent watchdog.

A three-way power mode (run, sleep, stop) is held in a small state machine. A sleep request stops only the CPU, while memory interfaces follow their own sleep bits and the bridge shuts itself off when nothing behind it is enabled. A stop request shuts every core clock and every high-speed source. A wakeup event returns the block to run. From stop, a stabilization window holds the core clocks off after the oscillators restart. Once the watchdog has been started, by either the hardware option or a software strobe, the low-speed oscillator is held on until a full reset. The watchdog clock follows a fixed oscillator warm-up delay.

Top module: `lp_clkgate_ctrl`

## Requirements
- R1: After reset the mode is run: `cpu_ce`=1, all four oscillator/PLL enables (`hsi_en`, `hsi14_en`, `hse_en`, `pll_en`)=1, `lsi_en`=0 and `wdg_ce`=0.
- R2: In run and sleep, bit i of `periph_ce` equals bit i of `periph_en`, and `dma_ce` equals `dma_en`.
- R3: A `sleep_req` sampled in run (with `stop_req` low) moves the block to sleep on that edge, and `cpu_ce` is 0 throughout sleep.
- R4: `flash_ce` and `sram_ce` are 1 in run. In sleep, each is 0 exactly when its sleep-off bit (`flash_slp_off`, `sram_slp_off`) is 1.
- R5: `bridge_ce` is 1 in run. In sleep it is 1 exactly when at least one bit of `periph_en` is set.
- R6: In stop, every core enable (`cpu_ce`, `flash_ce`, `sram_ce`, `dma_ce`, `periph_ce`, `bridge_ce`) is 0 and `hsi_en`, `hsi14_en`, `hse_en`, `pll_en` are 0, whatever the software enables.
- R7: `stop_req` takes priority over `sleep_req` in run. `stop_req` in sleep enters stop. `wake_evt` in sleep returns to run on the sampling edge.
- R8: `wake_evt` sampled in stop turns the four oscillator/PLL enables on at that edge. The core enables stay 0 and return exactly STAB_CYCLES edges later (default 16).
- R9: A high level on `wdg_hw_opt` or `wdg_sw_start` makes `lsi_en` 1 from the next edge onward, regardless of `lsi_sw_en`, until reset. Without a start, `lsi_en` follows `lsi_sw_en`.
- R10: With the low-speed oscillator previously off, `wdg_ce` rises exactly LSI_DLY edges (default 8) after the edge that latched the watchdog start, and remains 1.
- R11: `wake_evt` in run and `sleep_req` in stop have no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low full reset |
| sleep_req | input | 1 | Request to enter sleep |
| stop_req | input | 1 | Request to enter stop |
| wake_evt | input | 1 | Wakeup event, returns to run |
| periph_en | input | N_PERIPH | Software enable per peripheral clock |
| dma_en | input | 1 | Software enable for the DMA clock |
| flash_slp_off | input | 1 | 1 stops the flash interface clock in sleep |
| sram_slp_off | input | 1 | 1 stops the SRAM interface clock in sleep |
| lsi_sw_en | input | 1 | Software enable for the low-speed oscillator |
| wdg_hw_opt | input | 1 | Watchdog started by hardware option |
| wdg_sw_start | input | 1 | Watchdog started by software write strobe |
| cpu_ce | output | 1 | CPU clock enable |
| flash_ce | output | 1 | Flash interface clock enable |
| sram_ce | output | 1 | SRAM interface clock enable |
| dma_ce | output | 1 | DMA clock enable |
| periph_ce | output | N_PERIPH | Peripheral clock enables |
| bridge_ce | output | 1 | Peripheral-bus bridge clock enable |
| hsi_en | output | 1 | High-speed internal oscillator enable |
| hsi14_en | output | 1 | 14 MHz internal oscillator enable |
| hse_en | output | 1 | High-speed external oscillator enable |
| pll_en | output | 1 | PLL enable |
| lsi_en | output | 1 | Low-speed internal oscillator enable |
| wdg_ce | output | 1 | Watchdog clock enable |

## Verification
The bench sweeps every combination of peripheral, DMA and memory sleep bits in both run and sleep. This catches a bridge that shuts off while one peripheral is still enabled, and a memory clock whose sleep bit has the wrong sense. It counts the stabilization window edge by edge after a wakeup from stop, so a window that is one cycle short or long, or oscillators that come back late, show up as a mismatch at a specific cycle. It issues sleep and stop together and stray wakeups and sleep requests in the wrong modes, which exposes an inverted priority or a mode that leaks. On the watchdog side it clears the software oscillator enable after a start and checks the warm-up edge exactly, which catches a force-on that is not sticky and an off-by-one delay.

// File: rtl/lpcg_pkg.sv
package lpcg_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_SLEEP = 2'd1,
    PM_STOP  = 2'd2,
    PM_WAKE  = 2'd3
  } pmode_t;
endpackage

// File: rtl/lpcg_mode_fsm.sv
module lpcg_mode_fsm
  import lpcg_pkg::*;
#(
  parameter int STAB_CYCLES = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sleep_req,
  input  logic   stop_req,
  input  logic   wake_evt,
  output pmode_t mode
);
  localparam int CW = $clog2(STAB_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

  pmode_t        mode_q, mode_d;
  logic [CW-1:0] stab_q, stab_d;

  always_comb begin
    mode_d = mode_q;
    stab_d = stab_q;
    unique case (mode_q)
      PM_RUN: begin
        if (stop_req)       mode_d = PM_STOP;
        else if (sleep_req) mode_d = PM_SLEEP;
      end
      PM_SLEEP: begin
        if (wake_evt)       mode_d = PM_RUN;
        else if (stop_req)  mode_d = PM_STOP;
      end
      PM_STOP: begin
        if (wake_evt) begin
          mode_d = PM_WAKE;
          stab_d = '0;
        end
      end
      PM_WAKE: begin
        if (stab_q == LAST) mode_d = PM_RUN;
        else                stab_d = stab_q + 1'b1;
      end
      default: mode_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_RUN;
      stab_q <= '0;
    end else begin
      mode_q <= mode_d;
      stab_q <= stab_d;
    end
  end

  assign mode = mode_q;
endmodule

// File: rtl/lpcg_gate_logic.sv
module lpcg_gate_logic
  import lpcg_pkg::*;
#(
  parameter int N_PERIPH = 4
) (
  input  pmode_t              mode,
  input  logic [N_PERIPH-1:0] periph_en,
  input  logic                dma_en,
  input  logic                flash_slp_off,
  input  logic                sram_slp_off,
  output logic                cpu_ce,
  output logic                flash_ce,
  output logic                sram_ce,
  output logic                dma_ce,
  output logic [N_PERIPH-1:0] periph_ce,
  output logic                bridge_ce,
  output logic                hs_osc_on
);
  logic in_run, in_sleep, bus_live;

  assign in_run   = (mode == PM_RUN);
  assign in_sleep = (mode == PM_SLEEP);
  assign bus_live = in_run | in_sleep;

  assign cpu_ce    = in_run;
  assign flash_ce  = in_run | (in_sleep & ~flash_slp_off);
  assign sram_ce   = in_run | (in_sleep & ~sram_slp_off);
  assign dma_ce    = bus_live & dma_en;
  assign bridge_ce = in_run | (in_sleep & (|periph_en));
  assign hs_osc_on = (mode != PM_STOP);

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_pgate
    assign periph_ce[i] = bus_live & periph_en[i];
  end
endmodule

// File: rtl/lpcg_lsi_wdg.sv
module lpcg_lsi_wdg #(
  parameter int LSI_DLY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lsi_sw_en,
  input  logic wdg_hw_opt,
  input  logic wdg_sw_start,
  output logic lsi_en,
  output logic wdg_ce
);
  localparam int DW = $clog2(LSI_DLY + 1);
  localparam logic [DW-1:0] DONE = DW'(LSI_DLY);

  logic          wdg_lock_q;
  logic [DW-1:0] warm_q;
  logic          lsi_ready;

  assign lsi_en    = lsi_sw_en | wdg_lock_q;
  assign lsi_ready = (warm_q == DONE);
  assign wdg_ce    = wdg_lock_q & lsi_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdg_lock_q <= 1'b0;
      warm_q     <= '0;
    end else begin
      if (wdg_hw_opt | wdg_sw_start) wdg_lock_q <= 1'b1;
      if (!lsi_en)         warm_q <= '0;
      else if (!lsi_ready) warm_q <= warm_q + 1'b1;
    end
  end
endmodule

// File: rtl/lp_clkgate_ctrl.sv
module lp_clkgate_ctrl
  import lpcg_pkg::*;
#(
  parameter int N_PERIPH    = 4,
  parameter int STAB_CYCLES = 16,
  parameter int LSI_DLY     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_req,
  input  logic                stop_req,
  input  logic                wake_evt,
  input  logic [N_PERIPH-1:0] periph_en,
  input  logic                dma_en,
  input  logic                flash_slp_off,
  input  logic                sram_slp_off,
  input  logic                lsi_sw_en,
  input  logic                wdg_hw_opt,
  input  logic                wdg_sw_start,
  output logic                cpu_ce,
  output logic                flash_ce,
  output logic                sram_ce,
  output logic                dma_ce,
  output logic [N_PERIPH-1:0] periph_ce,
  output logic                bridge_ce,
  output logic                hsi_en,
  output logic                hsi14_en,
  output logic                hse_en,
  output logic                pll_en,
  output logic                lsi_en,
  output logic                wdg_ce
);
  pmode_t mode;
  logic   hs_osc_on;

  lpcg_mode_fsm #(.STAB_CYCLES(STAB_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .stop_req  (stop_req),
    .wake_evt  (wake_evt),
    .mode      (mode)
  );

  lpcg_gate_logic #(.N_PERIPH(N_PERIPH)) u_gate (
    .mode          (mode),
    .periph_en     (periph_en),
    .dma_en        (dma_en),
    .flash_slp_off (flash_slp_off),
    .sram_slp_off  (sram_slp_off),
    .cpu_ce        (cpu_ce),
    .flash_ce      (flash_ce),
    .sram_ce       (sram_ce),
    .dma_ce        (dma_ce),
    .periph_ce     (periph_ce),
    .bridge_ce     (bridge_ce),
    .hs_osc_on     (hs_osc_on)
  );

  lpcg_lsi_wdg #(.LSI_DLY(LSI_DLY)) u_lsi (
    .clk          (clk),
    .rst_n        (rst_n),
    .lsi_sw_en    (lsi_sw_en),
    .wdg_hw_opt   (wdg_hw_opt),
    .wdg_sw_start (wdg_sw_start),
    .lsi_en       (lsi_en),
    .wdg_ce       (wdg_ce)
  );

  assign hsi_en   = hs_osc_on;
  assign hsi14_en = hs_osc_on;
  assign hse_en   = hs_osc_on;
  assign pll_en   = hs_osc_on;
endmodule

// File: rtl/lpcg_checker.sv
module lpcg_checker #(
  parameter int N_PERIPH = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sleep_req,
  input logic                stop_req,
  input logic                wake_evt,
  input logic [N_PERIPH-1:0] periph_en,
  input logic                wdg_hw_opt,
  input logic                wdg_sw_start,
  input logic                cpu_ce,
  input logic                flash_ce,
  input logic                sram_ce,
  input logic                dma_ce,
  input logic [N_PERIPH-1:0] periph_ce,
  input logic                bridge_ce,
  input logic                hse_en,
  input logic                pll_en,
  input logic                lsi_en,
  input logic                wdg_ce
);
  // R2: a peripheral clock never runs with its enable bit clear
  p_periph_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_ce & ~periph_en) == '0);

  // R3: run plus a lone sleep request leaves the CPU clock off next cycle
  p_sleep_cpu_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce && sleep_req && !stop_req) |=> !cpu_ce);

  // R5: a running peripheral always has its bridge clock running
  p_bridge_cover_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_ce != '0) |-> bridge_ce);

  // R6: with the high-speed sources off, the core domain is fully gated
  p_stop_all_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hse_en |-> (!cpu_ce && !flash_ce && !sram_ce && !dma_ce &&
                 periph_ce == '0 && !bridge_ce && !pll_en));

  // R8: oscillators restart before the core clocks do
  p_wake_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hse_en) |-> !cpu_ce);

  // R9: a watchdog start forces the low-speed oscillator on next cycle
  p_lsi_forced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wdg_hw_opt || wdg_sw_start) |=> lsi_en);

  // R10: the watchdog clock needs the oscillator and, once up, stays up
  p_wdg_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_ce |=> (wdg_ce && lsi_en));
endmodule

bind lp_clkgate_ctrl lpcg_checker #(.N_PERIPH(N_PERIPH)) u_chk (.*);

// File: tb/lp_clkgate_ctrl_bench.sv
module lp_clkgate_ctrl_bench;
  localparam int NP   = 4;
  localparam int STAB = 16;
  localparam int LDLY = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep_req = 0, stop_req = 0, wake_evt = 0;
  logic [NP-1:0] periph_en = '0;
  logic          dma_en = 0, flash_slp_off = 0, sram_slp_off = 0;
  logic          lsi_sw_en = 0, wdg_hw_opt = 0, wdg_sw_start = 0;
  logic          cpu_ce, flash_ce, sram_ce, dma_ce, bridge_ce;
  logic [NP-1:0] periph_ce;
  logic          hsi_en, hsi14_en, hse_en, pll_en, lsi_en, wdg_ce;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lp_clkgate_ctrl #(.N_PERIPH(NP), .STAB_CYCLES(STAB), .LSI_DLY(LDLY)) u_lp_clkgate_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stop_req(stop_req),
    .wake_evt(wake_evt), .periph_en(periph_en), .dma_en(dma_en),
    .flash_slp_off(flash_slp_off), .sram_slp_off(sram_slp_off),
    .lsi_sw_en(lsi_sw_en), .wdg_hw_opt(wdg_hw_opt), .wdg_sw_start(wdg_sw_start),
    .cpu_ce(cpu_ce), .flash_ce(flash_ce), .sram_ce(sram_ce), .dma_ce(dma_ce),
    .periph_ce(periph_ce), .bridge_ce(bridge_ce), .hsi_en(hsi_en),
    .hsi14_en(hsi14_en), .hse_en(hse_en), .pll_en(pll_en), .lsi_en(lsi_en),
    .wdg_ce(wdg_ce));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [31:0] core_vec();
    return {cpu_ce, flash_ce, sram_ce, dma_ce, bridge_ce, periph_ce};
  endfunction

  function automatic logic [31:0] osc_vec();
    return {hsi_en, hsi14_en, hse_en, pll_en};
  endfunction

  task automatic sweep(input bit sleeping);
    for (int v = 0; v < 128; v++) begin
      logic [NP-1:0] p;
      logic d, fo, so;
      p = v[3:0]; d = v[4]; fo = v[5]; so = v[6];
      periph_en = p; dma_en = d; flash_slp_off = fo; sram_slp_off = so;
      #1;
      chk("R2 periph", periph_ce, p);
      chk("R2 dma", dma_ce, d);
      chk("R4 flash", flash_ce, sleeping ? !fo : 1'b1);
      chk("R4 sram", sram_ce, sleeping ? !so : 1'b1);
      chk("R5 bridge", bridge_ce, sleeping ? (p != 0) : 1'b1);
      chk("R3 cpu", cpu_ce, !sleeping);
      chk("R6 osc on", osc_vec(), 4'hF);
    end
  endtask

  task automatic do_wake_from_stop();
    wake_evt = 1; step(); wake_evt = 0; #1;
    chk("R8 osc back", osc_vec(), 4'hF);
    chk("R8 core held", cpu_ce, 1'b0);
    for (int j = 1; j <= STAB; j++) begin
      step(); #1;
      chk("R8 stab window", cpu_ce, (j == STAB));
    end
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_run++; n_fail++;
          $display("FAIL watchdog: actual hung expected finished");
          $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
          $finish;
        end
      end
    join_none

    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    step(); #1;
    // R1 reset state
    chk("R1 cpu", cpu_ce, 1'b1);
    chk("R1 osc", osc_vec(), 4'hF);
    chk("R1 lsi", lsi_en, 1'b0);
    chk("R1 wdg", wdg_ce, 1'b0);

    sweep(1'b0);

    // R11 wake in run has no effect
    wake_evt = 1; step(); wake_evt = 0; #1;
    chk("R11 wake in run", cpu_ce, 1'b1);

    // R3 enter sleep
    sleep_req = 1; step(); sleep_req = 0; #1;
    chk("R3 sleep entered", cpu_ce, 1'b0);
    sweep(1'b1);

    // R7 wake from sleep
    wake_evt = 1; step(); wake_evt = 0; #1;
    chk("R7 sleep wake", cpu_ce, 1'b1);

    // R7 stop beats sleep; R6 all gated with enables on
    periph_en = '1; dma_en = 1; flash_slp_off = 0; sram_slp_off = 0;
    sleep_req = 1; stop_req = 1; step(); sleep_req = 0; stop_req = 0; #1;
    chk("R6 core off", core_vec(), 32'h0);
    chk("R6 osc off", osc_vec(), 4'h0);
    chk("R7 stop priority", pll_en, 1'b0);

    // R11 sleep request in stop ignored
    sleep_req = 1; step(); sleep_req = 0; step(); #1;
    chk("R11 sleep in stop", osc_vec(), 4'h0);
    chk("R11 core still off", core_vec(), 32'h0);

    do_wake_from_stop();

    // R7 sleep then stop
    sleep_req = 1; step(); sleep_req = 0;
    stop_req = 1; step(); stop_req = 0; #1;
    chk("R7 sleep to stop", osc_vec(), 4'h0);
    do_wake_from_stop();

    // R9 software enable path without a start
    lsi_sw_en = 1; #1;
    chk("R9 sw lsi on", lsi_en, 1'b1);
    lsi_sw_en = 0; step(); #1;
    chk("R9 sw lsi off", lsi_en, 1'b0);

    // R10 warm-up after software start
    wdg_sw_start = 1; step(); wdg_sw_start = 0; #1;
    chk("R9 forced", lsi_en, 1'b1);
    chk("R10 not ready", wdg_ce, 1'b0);
    for (int j = 1; j <= LDLY; j++) begin
      step(); #1;
      chk("R10 delay", wdg_ce, (j == LDLY));
    end
    lsi_sw_en = 1; step(); lsi_sw_en = 0; step(); #1;
    chk("R9 sticky lsi", lsi_en, 1'b1);
    chk("R10 wdg holds", wdg_ce, 1'b1);

    // R9 full reset clears the lock; hardware option path
    rst_n = 0; step(); rst_n = 1; step(); #1;
    chk("R9 reset clears", lsi_en, 1'b0);
    wdg_hw_opt = 1; step(); #1;
    chk("R9 hw option", lsi_en, 1'b1);
    wdg_hw_opt = 0; step(); #1;
    chk("R9 hw sticky", lsi_en, 1'b1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule